// File: doc/BRIEF.md
# Adaptive voltage code step controller

This block closes a voltage-adjustment loop for a single supply rail. A bank of timing-replica monitors sits on the rail. Each monitor raises one flag when its path is close to failing (slow) and another when it has plenty of spare time (slack). At a fixed, slow update interval the block reads a registered snapshot of these flags and votes. If any monitor is slow, the voltage target code goes up by one step. If every monitor has slack and none is slow, the code goes down by one step. In every other case the code holds. One code step equals 6.25 mV on the rail.

The code is kept between a programmable floor and a programmable ceiling. A starting code is loaded, clamped into that window, whenever the block is in reset or disabled. A request to go higher while the code already sits at the ceiling cannot be met. In that case the block raises a sticky fault that needs attention from outside the loop. The fault clears only on reset or when the block is disabled. A request to go lower at the floor is simply absorbed.

The update interval (20000 cycles by default), the monitor count (16) and the code width (8) are parameters.

Top module: `vstep_ctrl`

## Requirements
- R1: While reset is high, at the next rising edge `vcode_o` becomes the start code clamped into [floor, ceiling] and `sat_fault_o` becomes 0.
- R2: While `en_i` is low, `vcode_o` follows the clamped start code at every edge, `sat_fault_o` is 0, and monitor flags cause no change.
- R3: The clamp maps a start code above the ceiling to the ceiling and one below the floor to the floor; a code inside the window, including either bound, passes unchanged.
- R4: The code can change only at an update edge. Counting edges at which `en_i` is sampled high, the first update edge is the INTERVAL-th, and later ones follow every INTERVAL edges. Dropping `en_i` for any time restarts this count.
- R5: At an update edge, if any slow flag is set, the vote is "raise".
- R6: At an update edge, the vote is "lower" only when all slack flags are set and no slow flag is set; otherwise, with no slow flag, the code holds.
- R7: Each update moves the code by at most one LSB (one code unit, 6.25 mV).
- R8: A raise never takes the code above the ceiling; a raise at the ceiling leaves the code at the ceiling and sets `sat_fault_o` at that edge.
- R9: A lower never takes the code below the floor; a lower at the floor leaves the code unchanged and does not change `sat_fault_o`.
- R10: Once set, `sat_fault_o` stays 1 across later updates of either direction until reset or until `en_i` is sampled low.
- R11: The vote at an update edge uses the flags sampled at the previous edge; flags that change in the last cycle before the update edge do not affect that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Loop enable; low holds the clamped start code |
| slow_flag_i | input | NMON | Per-monitor low-margin flags |
| slack_flag_i | input | NMON | Per-monitor high-margin flags |
| floor_code_i | input | CODE_W | Lowest permitted code |
| ceil_code_i | input | CODE_W | Highest permitted code |
| start_code_i | input | CODE_W | Code loaded in reset and while disabled |
| vcode_o | output | CODE_W | Voltage target code |
| sat_fault_o | output | 1 | Sticky fault: raise blocked at the ceiling |

## Verification
Two events can fall on the same edge: the saturation of a raise at the ceiling, which sets the fault, and a clearing event, either disable or a later step-down that must leave the fault standing. The bench drives the code to the ceiling with slow flags, keeps raising so that the fault sets at the exact update edge, and then applies a lower vote. It checks that the code steps down while the fault stays set. It then drops enable and checks on the next edge that the fault is clear and the clamped start code is back. A second overlap, flags changing one cycle before an update edge, is judged by expecting the old snapshot's vote at that edge and the new one an interval later.

// File: rtl/vstep_pkg.sv
package vstep_pkg;

    // Decision taken from one registered snapshot of the monitor flags.
    typedef enum logic [1:0] {
        VOTE_HOLD  = 2'd0,
        VOTE_UP    = 2'd1,
        VOTE_DOWN  = 2'd2
    } vote_e;

    // Registered copy of the monitor flags; one struct per snapshot.
    typedef struct packed {
        logic any_slow;
        logic all_slack;
    } snap_sum_t;

    // Reduce a snapshot summary to a vote: any slow wins, then unanimous slack.
    function automatic vote_e decide(input snap_sum_t s);
        if (s.any_slow)
            return VOTE_UP;
        else if (s.all_slack)
            return VOTE_DOWN;
        else
            return VOTE_HOLD;
    endfunction

endpackage

// File: rtl/vstep_vote.sv
module vstep_vote
    import vstep_pkg::*;
#(
    parameter int NMON = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NMON-1:0] slow_i,
    input  logic [NMON-1:0] slack_i,
    output vote_e           vote_o
);

    logic [NMON-1:0] slow_q;
    logic [NMON-1:0] slack_q;
    snap_sum_t       sum;

    // Snapshot stage: the vote never sees flags mid-flight.
    always_ff @(posedge clk) begin
        if (rst) begin
            slow_q  <= '0;
            slack_q <= '0;
        end else begin
            slow_q  <= slow_i;
            slack_q <= slack_i;
        end
    end

    always_comb begin
        sum.any_slow  = |slow_q;
        sum.all_slack = &slack_q;
        vote_o        = decide(sum);
    end

    // A slow flag sampled at one edge makes the next cycle's vote a raise.
    assert_raise_vote_R5: assert property (@(posedge clk) disable iff (rst)
        (|slow_i) |=> (vote_o == VOTE_UP));

    // Lowering needs every slack flag and no slow flag in the snapshot.
    assert_lower_vote_R6: assert property (@(posedge clk) disable iff (rst)
        ((&slack_i) && !(|slow_i)) |=> (vote_o == VOTE_DOWN));

    // R11: flags sampled at an edge give a hold only when neither rule applies.
    assert_hold_vote_R11: assert property (@(posedge clk) disable iff (rst)
        (!(|slow_i) && !(&slack_i)) |=> (vote_o == VOTE_HOLD));

endmodule

// File: rtl/vstep_tick.sv
module vstep_tick #(
    parameter int INTERVAL = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic tick_o
);

    localparam int CNT_W = (INTERVAL < 2) ? 1 : $clog2(INTERVAL);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

    logic [CNT_W-1:0] cnt_q;

    // Free-running interval counter, restarted whenever the loop is off.
    always_ff @(posedge clk) begin
        if (rst || !en_i)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = en_i && (cnt_q == LAST);

    // Two update edges are never adjacent.
    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

    // Any disabled cycle forces a fresh interval.
    assert_tick_restart_R4: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !tick_o);

    always_comb begin
        assert_cnt_range_R4: assert (rst !== 1'b0 || cnt_q <= LAST);
    end

endmodule

// File: rtl/vstep_code.sv
module vstep_code
    import vstep_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              tick_i,
    input  vote_e             vote_i,
    input  logic [CODE_W-1:0] floor_i,
    input  logic [CODE_W-1:0] ceil_i,
    input  logic [CODE_W-1:0] start_i,
    output logic [CODE_W-1:0] code_o,
    output logic              fault_o
);

    logic [CODE_W-1:0] code_q;
    logic              fault_q;
    logic [CODE_W-1:0] start_fit;

    // Bring the start code into the window; the ceiling is tested first.
    function automatic logic [CODE_W-1:0] fit(
        input logic [CODE_W-1:0] v,
        input logic [CODE_W-1:0] lo,
        input logic [CODE_W-1:0] hi
    );
        if (v > hi)
            return hi;
        else if (v < lo)
            return lo;
        else
            return v;
    endfunction

    assign start_fit = fit(start_i, floor_i, ceil_i);

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            code_q  <= start_fit;
            fault_q <= 1'b0;
        end else if (tick_i) begin
            unique case (vote_i)
                VOTE_UP: begin
                    if (code_q >= ceil_i) begin
                        code_q  <= ceil_i;
                        fault_q <= 1'b1;
                    end else begin
                        code_q <= code_q + 1'b1;
                    end
                end
                VOTE_DOWN: begin
                    if (code_q <= floor_i)
                        code_q <= floor_i;
                    else
                        code_q <= code_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign code_o  = code_q;
    assign fault_o = fault_q;

    // Enabled cycles move the code by one unit at most.
    assert_one_lsb_R7: assert property (@(posedge clk) disable iff (rst)
        en_i |=> (code_q == $past(code_q) ||
                  code_q == $past(code_q) + 1'b1 ||
                  code_q == $past(code_q) - 1'b1));

    // Between update edges the code is frozen.
    assert_hold_off_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (en_i && !tick_i) |=> (code_q == $past(code_q)));

    // Blocked raise: pinned at the ceiling and faulted.
    assert_ceiling_fault_R8: assert property (@(posedge clk) disable iff (rst)
        (en_i && tick_i && vote_i == VOTE_UP && code_q >= ceil_i)
        |=> (fault_q && code_q == $past(ceil_i)));

    // Blocked lower: stays at floor and leaves the fault alone.
    assert_floor_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (en_i && tick_i && vote_i == VOTE_DOWN && code_q <= floor_i)
        |=> (code_q == $past(floor_i) && fault_q == $past(fault_q)));

    assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (en_i && fault_q) |=> fault_q);

    assert_off_no_fault_R2: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !fault_q);

endmodule

// File: rtl/vstep_ctrl.sv
module vstep_ctrl
    import vstep_pkg::*;
#(
    parameter int NMON     = 16,
    parameter int CODE_W   = 8,
    parameter int INTERVAL = 20000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [NMON-1:0]   slow_flag_i,
    input  logic [NMON-1:0]   slack_flag_i,
    input  logic [CODE_W-1:0] floor_code_i,
    input  logic [CODE_W-1:0] ceil_code_i,
    input  logic [CODE_W-1:0] start_code_i,
    output logic [CODE_W-1:0] vcode_o,
    output logic              sat_fault_o
);

    vote_e vote;
    logic  tick;

    vstep_vote #(.NMON(NMON)) u_vote (
        .clk     (clk),
        .rst     (rst),
        .slow_i  (slow_flag_i),
        .slack_i (slack_flag_i),
        .vote_o  (vote)
    );

    vstep_tick #(.INTERVAL(INTERVAL)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en_i),
        .tick_o (tick)
    );

    vstep_code #(.CODE_W(CODE_W)) u_code (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .tick_i  (tick),
        .vote_i  (vote),
        .floor_i (floor_code_i),
        .ceil_i  (ceil_code_i),
        .start_i (start_code_i),
        .code_o  (vcode_o),
        .fault_o (sat_fault_o)
    );

endmodule

// File: tb/tb_vstep_ctrl.sv
module tb_vstep_ctrl;

    localparam int NM = 4;
    localparam int CW = 4;
    localparam int IV = 5;
    localparam int FLO = 3;
    localparam int CEI = 12;
    localparam logic [NM-1:0] ALL = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic [NM-1:0] slow = '0;
    logic [NM-1:0] slack = '0;
    logic [CW-1:0] floor_c = CW'(FLO);
    logic [CW-1:0] ceil_c = CW'(CEI);
    logic [CW-1:0] start_c = CW'(7);
    logic [CW-1:0] vcode;
    logic          fault;

    int checks = 0;
    int errors = 0;
    int exp_code = 7;
    bit exp_fault = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vstep_ctrl #(.NMON(NM), .CODE_W(CW), .INTERVAL(IV)) dut (
        .clk          (clk),
        .rst          (rst),
        .en_i         (en),
        .slow_flag_i  (slow),
        .slack_flag_i (slack),
        .floor_code_i (floor_c),
        .ceil_code_i  (ceil_c),
        .start_code_i (start_c),
        .vcode_o      (vcode),
        .sat_fault_o  (fault)
    );

    task automatic edge1();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int fitc(input int v);
        if (v > CEI) return CEI;
        if (v < FLO) return FLO;
        return v;
    endfunction

    // One full interval with the given flags; update lands on the last edge.
    task automatic run_iv(input logic [NM-1:0] lo, input logic [NM-1:0] hi);
        string tag;
        slow  = lo;
        slack = hi;
        for (int i = 0; i < IV - 1; i++) begin
            edge1();
            chk("R4 code frozen between updates", int'(vcode), exp_code);
        end
        edge1();
        if (lo != '0) begin
            if (exp_code >= CEI) begin
                exp_code  = CEI;
                exp_fault = 1'b1;
                tag = "R8 raise at ceiling";
            end else begin
                exp_code++;
                tag = "R5 R7 raise one step";
            end
        end else if (hi == ALL) begin
            if (exp_code > FLO) begin
                exp_code--;
                tag = "R6 R7 lower one step";
            end else begin
                tag = "R9 lower at floor";
            end
        end else begin
            tag = "R6 hold";
        end
        chk(tag, int'(vcode), exp_code);
        chk({tag, " fault R10"}, int'(fault), int'(exp_fault));
    endtask

    initial begin
        // R1: reset loads the start code, no fault.
        edge1();
        edge1();
        chk("R1 reset code", int'(vcode), 7);
        chk("R1 reset fault", int'(fault), 0);
        rst = 1'b0;

        // R2: disabled, slow flags have no effect.
        slow = ALL;
        repeat (3 * IV) edge1();
        chk("R2 disabled code", int'(vcode), 7);
        chk("R2 disabled fault", int'(fault), 0);

        // R3: start code clamping, both bounds and interior.
        for (int v = 0; v < 16; v++) begin
            start_c = CW'(v);
            edge1();
            chk("R3 start clamp", int'(vcode), fitc(v));
        end
        start_c = CW'(7);
        edge1();

        // R4: first update after exactly IV enabled edges (hold vote).
        slow = '0;
        en = 1'b1;
        exp_code = 7;
        exp_fault = 1'b0;
        run_iv('0, '0);

        // R5 R6 R8 R9 R10: exhaustive flag sweep.
        for (int lo = 0; lo < 16; lo++)
            for (int hi = 0; hi < 16; hi++)
                run_iv(NM'(lo), NM'(hi));

        // Drive to ceiling, then lower: fault must stay (R10).
        for (int k = 0; k < 12; k++) run_iv(NM'(1), '0);
        chk("R8 at ceiling fault", int'(fault), 1);
        run_iv('0, ALL);
        chk("R10 fault kept after lower", int'(fault), 1);

        // Disable clears fault and reloads start code (R10, R2).
        en = 1'b0;
        edge1();
        chk("R10 disable clears fault", int'(fault), 0);
        chk("R2 disable reloads code", int'(vcode), 7);
        exp_code = 7;
        exp_fault = 1'b0;
        en = 1'b1;

        // Walk down to the floor; no fault there (R9).
        for (int k = 0; k < 7; k++) run_iv('0, ALL);
        chk("R9 floor reached", int'(vcode), FLO);
        chk("R9 no fault at floor", int'(fault), 0);

        // R4: a short disable restarts the interval count.
        slow = ALL;
        slack = '0;
        edge1();
        edge1();
        en = 1'b0;
        edge1();
        exp_code = 7;
        chk("R4 restart reload", int'(vcode), 7);
        en = 1'b1;
        run_iv(NM'(2), '0);
        chk("R4 first update after restart", int'(vcode), 8);

        // R11: flags changed one cycle before the update edge are not used yet.
        slow = '0;
        slack = ALL;
        repeat (IV - 1) edge1();
        slow = ALL;
        slack = '0;
        edge1();
        exp_code = 7;
        chk("R11 old snapshot lowers", int'(vcode), 7);
        repeat (IV) edge1();
        chk("R11 new snapshot raises", int'(vcode), 8);

        // R1: reset mid-run reloads and clears.
        rst = 1'b1;
        edge1();
        chk("R1 reset reload", int'(vcode), 7);
        chk("R1 reset fault clear", int'(fault), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule